// File: doc/BRIEF.md
# Nested Signed-Digit Shift-Add Multiplier

This block multiplies a signed fixed-point data word by a constant coefficient without a hardware multiplier. The coefficient is not stored as a binary number. It is a list of three signed-digit records, and each record holds a shift amount, a sign and a skip flag. The product is built in Horner form. A running value starts at zero. Each stage adds plus or minus the data word, or nothing, and then shifts the result right. The innermost digit is applied first. Because every stage only shifts right, the coefficient always lies below one in magnitude and the product keeps the fractional format of the data word.

Plain arithmetic right shifts truncate towards minus infinity, so negative values drift downward. Each stage therefore uses a corrected shift: a result of exactly minus one LSB becomes zero. The three stages are pipelined with one register each. A valid flag travels with the data, so a new operand pair can enter on every clock.

Top module: `sdm_mult`

## Requirements
- R1: The coefficient word is 10 bits wide and holds three digit records. Digit 0 (applied first) sits in bits [2:0], digit 1 in bits [5:3] and digit 2 in bits [9:6]. Inside each record the shift code takes the low bits (1 bit for digits 0 and 1, 2 bits for digit 2). The next bit above is the sign (1 = subtract), and the top bit is the skip flag (1 = add nothing).
- R2: A shift code decodes to a shift of code+2 for digits 0 and 1 (range 2 to 3) and code+1 for digit 2 (range 1 to 4).
- R3: With the running value starting at 0, each stage in digit order computes value = (value + sign*x) shifted right by the decoded amount. The output is the value after digit 2, in the data word's own fixed-point format. For example, x = 7.0 in 8 fractional bits (0x0700) with coefficient 0x04A gives 490 (0x01EA, about 1.914).
- R4: A digit with its skip flag set adds nothing, but its shift is still applied to the running value.
- R5: Every stage shifts arithmetically and then replaces a result of exactly -1 LSB with 0.
- R6: out_valid equals in_valid delayed by three rising clock edges, and the result for an operand pair appears together with that valid. Operands may arrive on consecutive cycles.
- R7: While out_valid is low, out_data keeps the last result that was delivered.
- R8: While reset is held and until the internal reset release, out_valid and out_data are 0.
- R9: The result is exact (per R3 to R5) for every data value, including the most negative and most positive, with no wrap in the intermediate sums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Marks in_data and in_coef as a new operand pair |
| in_data | input | DATA_W | Signed data word (two's complement, fixed-point) |
| in_coef | input | 10 | Packed three-digit coefficient (R1) |
| out_valid | output | 1 | Marks out_data as a new product |
| out_data | output | DATA_W | Signed product, same fixed-point format as in_data |

## Verification
A product is due three rising edges after its operands are captured, with out_valid high on that same edge. In every idle cycle the previous product must stay on out_data. The bench drives inputs on the falling edge and keeps a three-entry model pipeline that advances once per cycle. On each falling edge it compares out_valid and out_data against the entry that entered three edges earlier. If that entry is empty, the bench compares against the last delivered product instead. Directed cases check the worked example, the -1 LSB correction, skipped digits, the largest shift codes and full-scale data. Seeded random operands with gaps in the valid stream check the rest.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  localparam int NUM_STAGES = 3;

  // Width of the stored shift code for a stage.
  function automatic int stage_shift_w(input int k);
    return (k < 2) ? 1 : 2;
  endfunction

  // Offset added to the stored code to give the real shift.
  function automatic int stage_shift_base(input int k);
    return (k < 2) ? 2 : 1;
  endfunction

  // Record width: shift code, sign bit, skip bit.
  function automatic int digit_w(input int k);
    return stage_shift_w(k) + 2;
  endfunction

  // Bit position of a digit record inside the packed coefficient.
  function automatic int digit_lsb(input int k);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += digit_w(j);
    return acc;
  endfunction

  // Largest shift any stage can request.
  function automatic int max_shift();
    int m;
    m = 0;
    for (int j = 0; j < NUM_STAGES; j++)
      if (stage_shift_base(j) + (1 << stage_shift_w(j)) - 1 > m)
        m = stage_shift_base(j) + (1 << stage_shift_w(j)) - 1;
    return m;
  endfunction

  localparam int COEF_W  = digit_lsb(NUM_STAGES);
  localparam int SHAMT_W = $clog2(max_shift() + 1);

endpackage

// File: rtl/sdm_unbias_shr.sv
module sdm_unbias_shr #(
  parameter int W     = 18,
  parameter int AMT_W = 3
) (
  input  logic signed [W-1:0]     din,
  input  logic        [AMT_W-1:0] amt,
  output logic signed [W-1:0]     dout
);

  logic signed [W-1:0] shifted;

  always_comb begin
    shifted = din >>> amt;
    // R5: a -1 LSB residue left by truncation is mapped to zero
    if (&shifted) dout = '0;
    else          dout = shifted;
  end

endmodule

// File: rtl/sdm_stage.sv
module sdm_stage
  import sdm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 18,
  parameter int STAGE  = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vin,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [ACC_W-1:0]  acc_in,
  input  logic [digit_w(STAGE)-1:0] digit,
  output logic                     vout,
  output logic signed [ACC_W-1:0]  acc_out
);

  localparam int SH_W = stage_shift_w(STAGE);
  localparam int BASE = stage_shift_base(STAGE);

  logic [SH_W-1:0]           code;
  logic                      neg;
  logic                      skip;
  logic signed [ACC_W-1:0]   x_ext;
  logic signed [ACC_W-1:0]   addend;
  logic signed [ACC_W-1:0]   sum;
  logic [SHAMT_W-1:0]        amt;
  logic signed [ACC_W-1:0]   acc_nxt;
  logic                      v_nxt;
  logic signed [ACC_W-1:0]   acc_q;
  logic                      v_q;

  assign code = digit[SH_W-1:0];
  assign neg  = digit[SH_W];
  assign skip = digit[SH_W+1];

  // Next-state: add/subtract/skip, then corrected shift
  always_comb begin
    x_ext = ACC_W'(x_in);
    if (skip)     addend = '0;
    else if (neg) addend = -x_ext;
    else          addend = x_ext;
    sum   = acc_in + addend;
    amt   = SHAMT_W'(code) + SHAMT_W'(BASE);
    v_nxt = vin;
  end

  sdm_unbias_shr #(
    .W     (ACC_W),
    .AMT_W (SHAMT_W)
  ) u_shr (
    .din  (sum),
    .amt  (amt),
    .dout (acc_nxt)
  );

  // Registers: value loads only on a valid operand
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      acc_q <= '0;
    end else begin
      v_q <= v_nxt;
      if (vin) acc_q <= acc_nxt;
    end
  end

  assign vout    = v_q;
  assign acc_out = acc_q;

  // R6: valid advances one stage per clock
  a_r6_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
    vin |=> vout);
  a_r6_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
    !vin |=> !vout);
  // R7: stage value held when no operand is present
  a_r7_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    !vin |=> $stable(acc_out));
  // R5: no stage ever delivers the -1 LSB residue
  a_r5_no_neg_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    vout |-> !(&acc_out));
  // R4: a skipped digit on a zero running value yields zero
  a_r4_skip_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (vin && skip && (acc_in == '0)) |=> (acc_out == '0));

endmodule

// File: rtl/sdm_mult.sv
module sdm_mult
  import sdm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic [COEF_W-1:0]        in_coef,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);

  localparam int ACC_W = DATA_W + GUARD_W;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  logic                    v_c   [NUM_STAGES+1];
  logic signed [ACC_W-1:0] acc_c [NUM_STAGES+1];

  assign v_c[0]   = in_valid;
  assign acc_c[0] = '0;

  // Delay lines for the data word and the digits not yet consumed
  for (genvar k = 0; k < NUM_STAGES - 1; k++) begin : g_dl
    localparam int RW = COEF_W - digit_lsb(k + 1);
    logic [RW-1:0]             rest_d;
    logic [RW-1:0]             rest_q;
    logic signed [DATA_W-1:0]  x_d;
    logic signed [DATA_W-1:0]  x_q;

    if (k == 0) begin : g_src_in
      assign rest_d = in_coef[COEF_W-1:digit_lsb(1)];
      assign x_d    = in_data;
    end else begin : g_src_prev
      assign rest_d = g_dl[k-1].rest_q[COEF_W-digit_lsb(k)-1:digit_w(k)];
      assign x_d    = g_dl[k-1].x_q;
    end

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) begin
        rest_q <= '0;
        x_q    <= '0;
      end else if (v_c[k]) begin
        rest_q <= rest_d;
        x_q    <= x_d;
      end
    end
  end

  // Horner stages, innermost digit first
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_st
    localparam int DW = digit_w(k);
    logic [DW-1:0]            dig;
    logic signed [DATA_W-1:0] xs;

    if (k == 0) begin : g_first
      assign dig = in_coef[DW-1:0];
      assign xs  = in_data;
    end else begin : g_later
      assign dig = g_dl[k-1].rest_q[DW-1:0];
      assign xs  = g_dl[k-1].x_q;
    end

    sdm_stage #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W),
      .STAGE  (k)
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .vin     (v_c[k]),
      .x_in    (xs),
      .acc_in  (acc_c[k]),
      .digit   (dig),
      .vout    (v_c[k+1]),
      .acc_out (acc_c[k+1])
    );
  end

  assign out_valid = v_c[NUM_STAGES];
  assign out_data  = acc_c[NUM_STAGES][DATA_W-1:0];

  // R9: guard bits of the final value are pure sign extension
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid |-> ((&acc_c[NUM_STAGES][ACC_W-1:DATA_W-1]) ||
                   !(|acc_c[NUM_STAGES][ACC_W-1:DATA_W-1])));
  // R8: nothing is delivered during internal reset
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n_s |-> !out_valid);

endmodule

// File: tb/sdm_mult_test.sv
module sdm_mult_test;

  localparam int DW = 16;

  logic                 clk;
  logic                 rst_n;
  logic                 in_valid;
  logic signed [DW-1:0] in_data;
  logic [9:0]           in_coef;
  logic                 out_valid;
  logic signed [DW-1:0] out_data;

  int n_tests;
  int n_fail;
  bit done;

  sdm_mult #(.DATA_W(DW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_coef   (in_coef),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Model pipeline: entry 0 = captured on the latest edge
  logic   mv [3];
  longint md [3];
  string  mt [3];
  logic   cur_v;
  longint cur_exp;
  string  cur_t;
  longint last_out;

  // Reference product from the requirement text (R1, R2, R3, R4, R5)
  function automatic longint ref_product(longint x, logic [9:0] c);
    longint acc;
    int     sh;
    logic   sg, sk;
    acc = 0;
    for (int k = 0; k < 3; k++) begin
      case (k)
        0: begin sh = int'(c[0]) + 2;   sg = c[1]; sk = c[2]; end
        1: begin sh = int'(c[3]) + 2;   sg = c[4]; sk = c[5]; end
        default: begin sh = int'(c[7:6]) + 1; sg = c[8]; sk = c[9]; end
      endcase
      if (!sk) acc = sg ? acc - x : acc + x;
      acc = acc >>> sh;
      if (acc == -1) acc = 0;
    end
    return acc;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: advance model, compare outputs, apply new inputs
  task automatic step(logic v, logic signed [DW-1:0] x, logic [9:0] c, string tag);
    longint exp_d;
    logic   exp_v;
    @(negedge clk);
    mv[2] = mv[1]; md[2] = md[1]; mt[2] = mt[1];
    mv[1] = mv[0]; md[1] = md[0]; mt[1] = mt[0];
    mv[0] = cur_v; md[0] = cur_exp; mt[0] = cur_t;
    exp_v = mv[2];
    if (exp_v) begin
      exp_d    = md[2];
      last_out = exp_d;
    end else begin
      exp_d = last_out;
    end
    check(out_valid == exp_v, "R6 valid", longint'(out_valid), longint'(exp_v));
    check(longint'(out_data) == exp_d, exp_v ? mt[2] : "R7 hold",
          longint'(out_data), exp_d);
    in_valid = v;
    in_data  = x;
    in_coef  = c;
    cur_v    = v;
    cur_exp  = ref_product(longint'(x), c);
    cur_t    = tag;
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    for (int i = 0; i < 3; i++) begin mv[i] = 1'b0; md[i] = 0; mt[i] = ""; end
    cur_v = 1'b0; cur_exp = 0; cur_t = ""; last_out = 0;
    void'($urandom(32'd24681));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_coef = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 reset valid", longint'(out_valid), 0);
    check(out_data == '0, "R8 reset data", longint'(out_data), 0);
    rst_n = 1'b1;
    // Internal release: outputs stay quiet (R8), compared by step()
    repeat (4) step(1'b0, '0, '0, "R8");

    // R3 worked example: 7.0 * coef 0x04A -> 490
    step(1'b1, 16'sh0700, 10'h04A, "R3 example");
    // R1 field positions: negative outer digit
    step(1'b1, 16'sh0700, 10'b0101_001_010, "R1 digit fields");
    // R5 residue removal
    step(1'b1, -16'sd1, 10'b1000_100_000, "R5 minus one");
    step(1'b1, -16'sd3, 10'b1000_100_000, "R5 minus three");
    // R4 skipped digits
    step(1'b1, 16'sd12345, 10'b1000_100_100, "R4 all skipped");
    step(1'b1, 16'sd100, 10'b1000_100_000, "R4 skip shifts");
    // R2 largest shift codes
    step(1'b1, 16'sh4000, 10'b0011_001_001, "R2 max shifts");
    step(1'b0, '0, '0, "idle");
    step(1'b0, '0, '0, "idle");
    // R9 full-scale data
    step(1'b1, -16'sd32768, 10'b0000_000_000, "R9 min add");
    step(1'b1, -16'sd32768, 10'b0000_000_010, "R9 min sub");
    step(1'b1, 16'sd32767, 10'b0000_000_000, "R9 max add");
    step(1'b1, 16'sd32767, 10'b0101_010_010, "R9 max sub");
    step(1'b0, '0, '0, "idle");
    step(1'b0, '0, '0, "idle");
    step(1'b0, '0, '0, "idle");
    step(1'b0, '0, '0, "idle");

    // Random stream with gaps (R3, R6, R7)
    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom % 10) < 7;
      step(v, DW'($urandom), 10'($urandom), "R3 random");
    end
    repeat (5) step(1'b0, '0, '0, "flush");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule